// File: doc/BRIEF.md
# Stack and Vector Sequencer

This block carries out the memory traffic an 8-bit processor needs for its stack and for control transfers: loading the start address, pushing and pulling single bytes, pushing and pulling the status byte, subroutine call and return, software break and return from interrupt. It owns the program counter, the 8-bit stack pointer and the status byte. It drives a single-byte memory port with one access per cycle. Arithmetic and operand addressing belong to other blocks. Those blocks supply the current program counter, the current status byte, a byte to push and a call target along with each command.

A command is presented on `cmd_valid_i` together with its operands. It is accepted in any cycle where the block is idle. `busy_o` then stays high for exactly the cycles that carry memory accesses. `done_o` pulses for one cycle once every register has its new value. The stack is fixed to page 1, so every stack address is 0x0100 plus the stack pointer.

Top module: `stack_seq`

## Requirements
- R1: Command codes on `cmd_op_i` are 0 start, 1 push byte, 2 push status, 3 pull byte, 4 pull status, 5 call, 6 return, 7 break and 8 interrupt return. The start command sets SP to 0xFD and reads address 0xFFFC (low byte) and then 0xFFFD (high byte) into the PC.
- R2: Every stack access uses address 0x0100+SP. A stack write uses the current SP and then decrements SP. A stack read first increments SP and then reads at the new value.
- R3: Push byte writes `cmd_data_i` to the stack. Pull byte reads one stack byte and presents it on `pull_data_o`.
- R4: Push status writes `cmd_sr_i` with bit 4 (0x10) forced to 1. Pull status loads the read byte into `sr_o` with bit 5 (0x20) forced to 1.
- R5: Call writes `cmd_pc_i`-1 to the stack, high byte first and then low byte. It then loads `cmd_addr_i` into the PC, so SP drops by 2.
- R6: Return reads the low byte and then the high byte from the stack. It loads that word plus 1 into the PC, so SP rises by 2.
- R7: Break writes `cmd_pc_i`+1 (high byte, then low byte) and then `cmd_sr_i` with bit 4 set. It sets `sr_o` to `cmd_sr_i` with bit 2 (0x04) set, and reads the PC from 0xFFFE (low) and 0xFFFF (high).
- R8: Interrupt return reads the status byte unmodified into `sr_o`, then the PC low byte and then the high byte. No +1 is applied.
- R9: SP wraps modulo 256 in both directions and raises no error.
- R10: `busy_o` is high for exactly one cycle per memory access of the command. `done_o` pulses for a single cycle after the last access. A command presented while busy is ignored.
- R11: A command code above 8 is ignored. No access is made and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 4 | Command code |
| cmd_data_i | input | 8 | Byte for push byte |
| cmd_sr_i | input | 8 | Current status byte for push status and break |
| cmd_pc_i | input | 16 | Address of the next instruction, for call and break |
| cmd_addr_i | input | 16 | Call target |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 16 | Access address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid in the access cycle |
| pc_o | output | 16 | Program counter |
| sp_o | output | 8 | Stack pointer |
| sr_o | output | 8 | Status byte |
| pull_data_o | output | 8 | Last byte pulled by pull byte |

## Verification
The properties assume that memory returns read data in the same cycle as the request. They also assume that operands matter only in the cycle a command is accepted, so traffic on `mem_addr_o` depends on the stack pointer and the command alone. The bench's memory model answers reads combinationally from its own page-1 array and vector bytes. It drives new commands only at the falling edge, one at a time, except for the deliberate busy-time and bad-code attempts. The stack-pointer properties also assume that nothing but the block touches the pointer, and the start command is the only command that reloads it.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  localparam int STEP_W = 3;

  typedef enum logic [3:0] {
    OP_START   = 4'd0,
    OP_PUSH    = 4'd1,
    OP_PUSH_SR = 4'd2,
    OP_PULL    = 4'd3,
    OP_PULL_SR = 4'd4,
    OP_CALL    = 4'd5,
    OP_RET     = 4'd6,
    OP_BRK     = 4'd7,
    OP_IRET    = 4'd8
  } op_e;

  typedef enum logic [1:0] {
    ACC_STK_WR,
    ACC_STK_RD,
    ACC_VEC_RD
  } acc_e;

  typedef enum logic [1:0] {
    WS_HI,
    WS_LO,
    WS_BYTE,
    WS_SR
  } wsel_e;

  typedef enum logic [3:0] {
    DS_NONE,
    DS_LO,
    DS_HI,
    DS_HI_INC,
    DS_BYTE,
    DS_SR_FIX,
    DS_SR_RAW,
    DS_SR_INT,
    DS_TGT
  } dsel_e;

  typedef struct packed {
    acc_e        acc;
    wsel_e       wsel;
    dsel_e       dsel;
    logic [1:0]  vec_sel;  // [1] break vector, [0] high byte
    logic        last;
  } uop_t;

  function automatic uop_t mk(acc_e a, wsel_e w, dsel_e d, logic [1:0] v, logic l);
    uop_t u;
    u.acc = a; u.wsel = w; u.dsel = d; u.vec_sel = v; u.last = l;
    return u;
  endfunction

  function automatic uop_t uop_lookup(op_e op, logic [STEP_W-1:0] step);
    uop_t u;
    u = mk(ACC_VEC_RD, WS_BYTE, DS_NONE, 2'b00, 1'b1);
    unique case (op)
      OP_START:   u = (step == 0) ? mk(ACC_VEC_RD, WS_BYTE, DS_LO, 2'b00, 1'b0)
                                  : mk(ACC_VEC_RD, WS_BYTE, DS_HI, 2'b01, 1'b1);
      OP_PUSH:    u = mk(ACC_STK_WR, WS_BYTE, DS_NONE, 2'b00, 1'b1);
      OP_PUSH_SR: u = mk(ACC_STK_WR, WS_SR, DS_NONE, 2'b00, 1'b1);
      OP_PULL:    u = mk(ACC_STK_RD, WS_BYTE, DS_BYTE, 2'b00, 1'b1);
      OP_PULL_SR: u = mk(ACC_STK_RD, WS_BYTE, DS_SR_FIX, 2'b00, 1'b1);
      OP_CALL:    u = (step == 0) ? mk(ACC_STK_WR, WS_HI, DS_NONE, 2'b00, 1'b0)
                                  : mk(ACC_STK_WR, WS_LO, DS_TGT, 2'b00, 1'b1);
      OP_RET:     u = (step == 0) ? mk(ACC_STK_RD, WS_BYTE, DS_LO, 2'b00, 1'b0)
                                  : mk(ACC_STK_RD, WS_BYTE, DS_HI_INC, 2'b00, 1'b1);
      OP_BRK: begin
        case (step)
          3'd0:    u = mk(ACC_STK_WR, WS_HI, DS_NONE, 2'b00, 1'b0);
          3'd1:    u = mk(ACC_STK_WR, WS_LO, DS_NONE, 2'b00, 1'b0);
          3'd2:    u = mk(ACC_STK_WR, WS_SR, DS_SR_INT, 2'b00, 1'b0);
          3'd3:    u = mk(ACC_VEC_RD, WS_BYTE, DS_LO, 2'b10, 1'b0);
          default: u = mk(ACC_VEC_RD, WS_BYTE, DS_HI, 2'b11, 1'b1);
        endcase
      end
      OP_IRET: begin
        case (step)
          3'd0:    u = mk(ACC_STK_RD, WS_BYTE, DS_SR_RAW, 2'b00, 1'b0);
          3'd1:    u = mk(ACC_STK_RD, WS_BYTE, DS_LO, 2'b00, 1'b0);
          default: u = mk(ACC_STK_RD, WS_BYTE, DS_HI, 2'b00, 1'b1);
        endcase
      end
      default: u = mk(ACC_VEC_RD, WS_BYTE, DS_NONE, 2'b00, 1'b1);
    endcase
    return u;
  endfunction

endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [3:0] cmd_op_i,
  output logic       accept_o,
  output logic       busy_o,
  output logic       done_o,
  output acc_e       acc_o,
  output wsel_e      wsel_o,
  output dsel_e      dsel_o,
  output logic [1:0] vec_sel_o
);

  op_e               op_q;
  logic [STEP_W-1:0] step_q;
  logic              busy_q;
  logic              done_q;
  uop_t              uop;

  assign accept_o = cmd_valid_i && !busy_q && (cmd_op_i <= OP_IRET);
  assign uop      = uop_lookup(op_q, step_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_START;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q && uop.last;
      if (accept_o) begin
        op_q   <= op_e'(cmd_op_i);
        step_q <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (uop.last) busy_q <= 1'b0;
        else          step_q <= step_q + 1'b1;
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign acc_o     = uop.acc;
  assign wsel_o    = uop.wsel;
  assign dsel_o    = uop.dsel;
  assign vec_sel_o = uop.vec_sel;

endmodule

// File: rtl/stack_seq_addr.sv
module stack_seq_addr
  import stack_seq_pkg::*;
#(
  parameter int                    DATA_W     = 8,
  parameter logic [DATA_W-1:0]     STACK_PAGE = 8'h01,
  parameter logic [2*DATA_W-1:0]   RST_VEC    = 16'hFFFC,
  parameter logic [2*DATA_W-1:0]   BRK_VEC    = 16'hFFFE,
  parameter int                    B_POS      = 4
) (
  input  logic                  busy_i,
  input  acc_e                  acc_i,
  input  wsel_e                 wsel_i,
  input  logic [1:0]            vec_sel_i,
  input  logic [DATA_W-1:0]     sp_i,
  input  logic [2*DATA_W-1:0]   word_i,
  input  logic [DATA_W-1:0]     byte_i,
  input  logic [DATA_W-1:0]     sr_in_i,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [2*DATA_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]     mem_wdata_o
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] B_MASK = DATA_W'(1) << B_POS;

  logic [ADDR_W-1:0] vec_base;
  logic [DATA_W-1:0] sp_pre;

  assign vec_base = vec_sel_i[1] ? BRK_VEC : RST_VEC;
  assign sp_pre   = sp_i + DATA_W'(1);

  always_comb begin
    mem_we_o   = 1'b0;
    mem_addr_o = vec_base + {{(ADDR_W-1){1'b0}}, vec_sel_i[0]};
    unique case (acc_i)
      ACC_STK_WR: begin
        mem_we_o   = busy_i;
        mem_addr_o = {STACK_PAGE, sp_i};
      end
      ACC_STK_RD: mem_addr_o = {STACK_PAGE, sp_pre};
      default:    ;
    endcase
  end

  always_comb begin
    unique case (wsel_i)
      WS_HI:   mem_wdata_o = word_i[ADDR_W-1:DATA_W];
      WS_LO:   mem_wdata_o = word_i[DATA_W-1:0];
      WS_SR:   mem_wdata_o = sr_in_i | B_MASK;
      default: mem_wdata_o = byte_i;
    endcase
  end

  assign mem_req_o = busy_i;

endmodule

// File: rtl/stack_seq_regs.sv
module stack_seq_regs
  import stack_seq_pkg::*;
#(
  parameter int                DATA_W  = 8,
  parameter logic [DATA_W-1:0] SP_INIT = 8'hFD,
  parameter int                I_POS   = 2,
  parameter int                FIX_POS = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  accept_i,
  input  logic [3:0]            cmd_op_i,
  input  logic [DATA_W-1:0]     cmd_data_i,
  input  logic [DATA_W-1:0]     cmd_sr_i,
  input  logic [2*DATA_W-1:0]   cmd_pc_i,
  input  logic [2*DATA_W-1:0]   cmd_addr_i,
  input  logic                  busy_i,
  input  acc_e                  acc_i,
  input  dsel_e                 dsel_i,
  input  logic [DATA_W-1:0]     mem_rdata_i,
  output logic [2*DATA_W-1:0]   pc_o,
  output logic [DATA_W-1:0]     sp_o,
  output logic [DATA_W-1:0]     sr_o,
  output logic [DATA_W-1:0]     pull_data_o,
  output logic [2*DATA_W-1:0]   word_o,
  output logic [DATA_W-1:0]     byte_o,
  output logic [DATA_W-1:0]     sr_in_o
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] ONE_A    = ADDR_W'(1);
  localparam logic [DATA_W-1:0] ONE_D    = DATA_W'(1);
  localparam logic [DATA_W-1:0] I_MASK   = ONE_D << I_POS;
  localparam logic [DATA_W-1:0] FIX_MASK = ONE_D << FIX_POS;

  logic [ADDR_W-1:0] pc_q, word_q, tgt_q, rd_word;
  logic [DATA_W-1:0] sp_q, sr_q, pull_q, byte_q, sr_in_q, lo_q;

  assign rd_word = {mem_rdata_i, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      sp_q    <= SP_INIT;
      sr_q    <= FIX_MASK;
      pull_q  <= '0;
      word_q  <= '0;
      tgt_q   <= '0;
      byte_q  <= '0;
      sr_in_q <= '0;
      lo_q    <= '0;
    end else if (accept_i) begin
      byte_q  <= cmd_data_i;
      sr_in_q <= cmd_sr_i;
      tgt_q   <= cmd_addr_i;
      // call stacks the address minus one; break skips one padding byte
      word_q  <= (cmd_op_i == OP_CALL) ? cmd_pc_i - ONE_A : cmd_pc_i + ONE_A;
      if (cmd_op_i == OP_START) sp_q <= SP_INIT;
    end else if (busy_i) begin
      unique case (acc_i)
        ACC_STK_WR: sp_q <= sp_q - ONE_D;
        ACC_STK_RD: sp_q <= sp_q + ONE_D;
        default:    ;
      endcase
      unique case (dsel_i)
        DS_LO:     lo_q   <= mem_rdata_i;
        DS_HI:     pc_q   <= rd_word;
        DS_HI_INC: pc_q   <= rd_word + ONE_A;
        DS_BYTE:   pull_q <= mem_rdata_i;
        DS_SR_FIX: sr_q   <= mem_rdata_i | FIX_MASK;
        DS_SR_RAW: sr_q   <= mem_rdata_i;
        DS_SR_INT: sr_q   <= sr_in_q | I_MASK;
        DS_TGT:    pc_q   <= tgt_q;
        default:   ;
      endcase
    end
  end

  assign pc_o        = pc_q;
  assign sp_o        = sp_q;
  assign sr_o        = sr_q;
  assign pull_data_o = pull_q;
  assign word_o      = word_q;
  assign byte_o      = byte_q;
  assign sr_in_o     = sr_in_q;

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int                  DATA_W     = 8,
  parameter logic [DATA_W-1:0]   STACK_PAGE = 8'h01,
  parameter logic [DATA_W-1:0]   SP_INIT    = 8'hFD,
  parameter logic [2*DATA_W-1:0] RST_VEC    = 16'hFFFC,
  parameter logic [2*DATA_W-1:0] BRK_VEC    = 16'hFFFE,
  parameter int                  B_POS      = 4,
  parameter int                  I_POS      = 2,
  parameter int                  FIX_POS    = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [3:0]          cmd_op_i,
  input  logic [DATA_W-1:0]   cmd_data_i,
  input  logic [DATA_W-1:0]   cmd_sr_i,
  input  logic [2*DATA_W-1:0] cmd_pc_i,
  input  logic [2*DATA_W-1:0] cmd_addr_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [2*DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic [2*DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0]   sp_o,
  output logic [DATA_W-1:0]   sr_o,
  output logic [DATA_W-1:0]   pull_data_o
);

  localparam int ADDR_W = 2 * DATA_W;

  logic              accept;
  acc_e              acc;
  wsel_e             wsel;
  dsel_e             dsel;
  logic [1:0]        vec_sel;
  logic [ADDR_W-1:0] word;
  logic [DATA_W-1:0] byte_op, sr_in;

  stack_seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .accept_o    (accept),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .acc_o       (acc),
    .wsel_o      (wsel),
    .dsel_o      (dsel),
    .vec_sel_o   (vec_sel)
  );

  stack_seq_addr #(
    .DATA_W     (DATA_W),
    .STACK_PAGE (STACK_PAGE),
    .RST_VEC    (RST_VEC),
    .BRK_VEC    (BRK_VEC),
    .B_POS      (B_POS)
  ) u_addr (
    .busy_i      (busy_o),
    .acc_i       (acc),
    .wsel_i      (wsel),
    .vec_sel_i   (vec_sel),
    .sp_i        (sp_o),
    .word_i      (word),
    .byte_i      (byte_op),
    .sr_in_i     (sr_in),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  stack_seq_regs #(
    .DATA_W  (DATA_W),
    .SP_INIT (SP_INIT),
    .I_POS   (I_POS),
    .FIX_POS (FIX_POS)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .cmd_op_i    (cmd_op_i),
    .cmd_data_i  (cmd_data_i),
    .cmd_sr_i    (cmd_sr_i),
    .cmd_pc_i    (cmd_pc_i),
    .cmd_addr_i  (cmd_addr_i),
    .busy_i      (busy_o),
    .acc_i       (acc),
    .dsel_i      (dsel),
    .mem_rdata_i (mem_rdata_i),
    .pc_o        (pc_o),
    .sp_o        (sp_o),
    .sr_o        (sr_o),
    .pull_data_o (pull_data_o),
    .word_o      (word),
    .byte_o      (byte_op),
    .sr_in_o     (sr_in)
  );

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cmd_valid_i,
  input logic [3:0]          cmd_op_i,
  input logic                busy_o,
  input logic                done_o,
  input logic                mem_req_o,
  input logic                mem_we_o,
  input logic [2*DATA_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0]   sp_o
);

  localparam int ADDR_W = 2 * DATA_W;

  logic stk_rd;
  assign stk_rd = mem_req_o && !mem_we_o && (mem_addr_o[ADDR_W-1:DATA_W] == STACK_PAGE);

  assert_addr_space_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[ADDR_W-1:DATA_W] == STACK_PAGE) ||
                  ((mem_addr_o | ADDR_W'(3)) == {ADDR_W{1'b1}}));

  assert_write_at_sp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_addr_o[DATA_W-1:0] == sp_o));

  assert_write_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |=> (sp_o == $past(sp_o) - DATA_W'(1)));

  assert_read_pre_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_rd |-> (mem_addr_o[DATA_W-1:0] == sp_o + DATA_W'(1)));

  assert_read_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_rd |=> (sp_o == $past(sp_o) + DATA_W'(1)));

  assert_wrap_down_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && sp_o == '0) |=> (sp_o == {DATA_W{1'b1}}));

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_idle_sp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(cmd_valid_i && cmd_op_i == 4'd0)) |=> $stable(sp_o));

endmodule

bind stack_seq stack_seq_chk #(.DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .sp_o        (sp_o)
);

// File: tb/stack_seq_test.sv
`timescale 1ns/1ps
module stack_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [7:0]  cmd_data = '0, cmd_sr = '0;
  logic [15:0] cmd_pc = '0, cmd_addr = '0;
  logic        busy, done, mem_req, mem_we;
  logic [15:0] mem_addr, pc;
  logic [7:0]  mem_wdata, mem_rdata, sp, sr, pull_data;

  always #2 clk = ~clk;

  stack_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_data_i(cmd_data), .cmd_sr_i(cmd_sr), .cmd_pc_i(cmd_pc), .cmd_addr_i(cmd_addr),
    .busy_o(busy), .done_o(done), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .pc_o(pc), .sp_o(sp), .sr_o(sr), .pull_data_o(pull_data)
  );

  typedef struct { logic [15:0] a; logic we; logic [7:0] d; string tag; } acc_t;
  acc_t exp_q[$];

  logic [7:0] stk [0:255];
  logic [7:0] stk_m [0:255];
  logic [7:0] vec [0:3];
  logic [7:0] sp_m;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  assign mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] :
                     (mem_addr[15:2] == 14'h3FFF) ? vec[mem_addr[1:0]] : 8'hEE;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected accesses and acts as the memory write port
  initial begin
    for (int i = 0; i < 256; i++) begin
      stk[i] = 8'(i) ^ 8'h5A;
      stk_m[i] = 8'(i) ^ 8'h5A;
    end
    vec[0] = 8'h34; vec[1] = 8'h12; vec[2] = 8'h78; vec[3] = 8'h56;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        if (exp_q.size() == 0) begin
          check("R10 unexpected access", {16'h0, mem_addr}, 32'hFFFFFFFF);
        end else begin
          acc_t e;
          e = exp_q.pop_front();
          check({e.tag, " addr"}, {16'h0, mem_addr}, {16'h0, e.a});
          check({e.tag, " we"}, {31'h0, mem_we}, {31'h0, e.we});
          if (e.we) check({e.tag, " wdata"}, {24'h0, mem_wdata}, {24'h0, e.d});
        end
        if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] = mem_wdata;
      end
    end
  end

  task automatic e_wr(string tag, logic [7:0] d);
    exp_q.push_back('{16'h0100 | {8'h0, sp_m}, 1'b1, d, tag});
    stk_m[sp_m] = d;
    sp_m = sp_m - 8'd1;
  endtask

  task automatic e_rd(string tag, output logic [7:0] d);
    sp_m = sp_m + 8'd1;
    exp_q.push_back('{16'h0100 | {8'h0, sp_m}, 1'b0, 8'h0, tag});
    d = stk_m[sp_m];
  endtask

  task automatic e_vec(string tag, logic [15:0] a);
    exp_q.push_back('{a, 1'b0, 8'h0, tag});
  endtask

  task automatic issue(string tag, logic [3:0] op, logic [7:0] d, logic [7:0] s,
                       logic [15:0] p, logic [15:0] t, int n_acc);
    int n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_sr = s; cmd_pc = p; cmd_addr = t;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (busy && n < 20) begin
      n++;
      @(negedge clk);
    end
    check({tag, " R10 busy cycles"}, n, n_acc);
    check({tag, " R10 done"}, {31'h0, done}, 32'h1);
    check({tag, " R10 queue drained"}, exp_q.size(), 0);
  endtask

  task automatic done_gone(string tag);
    @(negedge clk);
    check({tag, " R10 done one cycle"}, {31'h0, done}, 32'h0);
  endtask

  initial begin
    logic [7:0] b0, b1, b2;
    repeat (3) @(negedge clk);
    check("R1 reset busy", {31'h0, busy}, 0);
    check("R1 reset done", {31'h0, done}, 0);
    check("R1 reset sp", {24'h0, sp}, 32'hFD);
    rst_n = 1'b1;

    // R1 start
    sp_m = 8'hFD;
    e_vec("R1 vec lo", 16'hFFFC); e_vec("R1 vec hi", 16'hFFFD);
    issue("R1 start", 4'd0, 0, 0, 0, 0, 2);
    check("R1 pc", {16'h0, pc}, 32'h1234);
    check("R1 sp", {24'h0, sp}, 32'hFD);
    done_gone("R1");

    // R2 R3 push and pull bytes
    e_wr("R3 push a", 8'hA5);
    issue("R3 push a", 4'd1, 8'hA5, 0, 0, 0, 1);
    check("R2 sp after push", {24'h0, sp}, 32'hFC);
    e_wr("R3 push b", 8'h3C);
    issue("R3 push b", 4'd1, 8'h3C, 0, 0, 0, 1);
    e_rd("R3 pull b", b0);
    issue("R3 pull b", 4'd3, 0, 0, 0, 0, 1);
    check("R3 pull data b", {24'h0, pull_data}, {24'h0, b0});
    check("R2 sp after pull", {24'h0, sp}, 32'hFC);
    e_rd("R3 pull a", b0);
    issue("R3 pull a", 4'd3, 0, 0, 0, 0, 1);
    check("R3 pull data a", {24'h0, pull_data}, 32'hA5);

    // R4 status push forces 0x10, status pull forces 0x20
    e_wr("R4 push sr", 8'hC3 | 8'h10);
    issue("R4 push sr", 4'd2, 0, 8'hC3, 0, 0, 1);
    e_rd("R4 pull sr", b0);
    issue("R4 pull sr", 4'd4, 0, 0, 0, 0, 1);
    check("R4 sr forced", {24'h0, sr}, {24'h0, b0 | 8'h20});
    check("R4 sr value", {24'h0, sr}, 32'hF3);

    // R5 call, R6 return
    e_wr("R5 call hi", 8'h20); e_wr("R5 call lo", 8'h02);
    issue("R5 call", 4'd5, 0, 0, 16'h2003, 16'h4000, 2);
    check("R5 pc", {16'h0, pc}, 32'h4000);
    check("R5 sp", {24'h0, sp}, 32'hFB);
    e_rd("R6 ret lo", b0); e_rd("R6 ret hi", b1);
    issue("R6 ret", 4'd6, 0, 0, 0, 0, 2);
    check("R6 pc", {16'h0, pc}, {16'h0, ({b1, b0} + 16'h1)});
    check("R6 pc value", {16'h0, pc}, 32'h2003);
    check("R6 sp", {24'h0, sp}, 32'hFD);

    // R7 break, R8 interrupt return
    e_wr("R7 brk hi", 8'h30); e_wr("R7 brk lo", 8'h01); e_wr("R7 brk sr", 8'h11);
    e_vec("R7 vec lo", 16'hFFFE); e_vec("R7 vec hi", 16'hFFFF);
    issue("R7 brk", 4'd7, 0, 8'h01, 16'h3000, 0, 5);
    check("R7 pc", {16'h0, pc}, 32'h5678);
    check("R7 sr", {24'h0, sr}, 32'h05);
    check("R7 sp", {24'h0, sp}, 32'hFA);
    e_rd("R8 sr", b0); e_rd("R8 lo", b1); e_rd("R8 hi", b2);
    issue("R8 iret", 4'd8, 0, 0, 0, 0, 3);
    check("R8 sr raw", {24'h0, sr}, {24'h0, b0});
    check("R8 sr value", {24'h0, sr}, 32'h11);
    check("R8 pc", {16'h0, pc}, {16'h0, b2, b1});
    check("R8 pc value", {16'h0, pc}, 32'h3001);

    // R9 wrap both directions
    sp_m = 8'hFD;
    e_vec("R9 vec lo", 16'hFFFC); e_vec("R9 vec hi", 16'hFFFD);
    issue("R9 start", 4'd0, 0, 0, 0, 0, 2);
    e_rd("R9 pull fe", b0);
    issue("R9 pull fe", 4'd3, 0, 0, 0, 0, 1);
    e_rd("R9 pull ff", b0);
    issue("R9 pull ff", 4'd3, 0, 0, 0, 0, 1);
    e_rd("R9 pull 00", b0);
    issue("R9 pull 00", 4'd3, 0, 0, 0, 0, 1);
    check("R9 sp up wrap", {24'h0, sp}, 32'h00);
    check("R9 pull data", {24'h0, pull_data}, {24'h0, b0});
    e_wr("R9 push 00", 8'h77);
    issue("R9 push 00", 4'd1, 8'h77, 0, 0, 0, 1);
    check("R9 sp down wrap", {24'h0, sp}, 32'hFF);

    // R10 command during busy is ignored
    e_wr("R10 call hi", 8'h12); e_wr("R10 call lo", 8'h33);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 4'd5; cmd_pc = 16'h1234; cmd_addr = 16'hBEEF;
    @(negedge clk);
    cmd_op = 4'd1; cmd_data = 8'h99;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    check("R10 done after call", {31'h0, done}, 1);
    check("R10 sp ignores push", {24'h0, sp}, 32'hFD);
    check("R10 pc", {16'h0, pc}, 32'hBEEF);
    @(negedge clk);
    check("R10 no late accept", {31'h0, busy}, 0);
    check("R10 queue drained", exp_q.size(), 0);

    // R11 bad code ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 4'd12;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R11 no busy", {31'h0, busy}, 0);
    @(negedge clk);
    check("R11 sp kept", {24'h0, sp}, 32'hFD);
    check("R11 pc kept", {16'h0, pc}, 32'hBEEF);
    check("R11 no done", {31'h0, done}, 0);

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check("watchdog", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule